// File: doc/BRIEF.md
# Pipelined Float Narrowing and Widening Converter

This block converts the elements of a 2048-bit vector between single precision (binary32) and the two 16-bit float formats, binary16 and bfloat16. In the narrowing direction each of the 64 binary32 lanes yields one 16-bit result. A part select places every result either in the lower or in the upper 16-bit half of its 32-bit word, which are the even and the odd 16-bit slots of the destination. The slots that were not selected are written as zero. Two narrowing passes, one even and one odd, can therefore be merged into one packed 128-lane vector with a plain bitwise OR.

In the widening direction the part select picks the even or the odd 16-bit source slot of every 32-bit word and expands it exactly to binary32. Narrowing honours six rounding modes. Widening cannot be inexact, so it ignores the mode. A per-lane mask zeroes the destination word of every lane that is switched off.

The converter is fully pipelined. It accepts one operation per cycle, and each result appears a fixed seven cycles after its input, together with a valid flag.

Top module: `vec_fp_narrow_cvt`

## Requirements
- R1: A vector accepted with `inValid` high at a clock edge appears on `outVec` with `outValid` high exactly 7 rising edges later. Back-to-back inputs produce back-to-back outputs. While `outValid` is low, `outVec` is all zero, and reset clears the pipeline.
- R2: Narrowing (`fmtSel` 0 = binary32→binary16, 1 = binary32→bfloat16) writes the result of source word i to bits [32i+15:32i] when `partSel`=0 (even) and to bits [32i+31:32i+16] when `partSel`=1 (odd). The other half of the word is zero.
- R3: In narrowing, `inMask[i]` gates source word i and `inMask[127:64]` has no effect. In widening, `inMask[2i+partSel]` gates destination word i. A gated-off lane yields a zero 32-bit word.
- R4: `rndSel` 0 rounds to nearest with ties to even, and so do the unused codes 6 and 7. A result that is exactly halfway keeps the candidate with an even last mantissa bit.
- R5: `rndSel` 1 rounds away from zero, 2 toward minus infinity, 3 toward plus infinity, and 4 toward zero.
- R6: `rndSel` 5 rounds to odd. The value is truncated toward zero, and any inexact result gets its last mantissa bit set.
- R7: On overflow the result is infinity for modes 0, 1 and 6–7. It is the largest finite value for modes 4 and 5. Modes 2 and 3 give infinity on the side they round toward and the largest finite value on the other side.
- R8: A NaN input gives a NaN with the same sign, an all-ones exponent, the top mantissa bit set and the remaining mantissa bits zero. Infinity converts to infinity of the same sign in both directions.
- R9: binary16 results in the subnormal range are rounded correctly under the selected mode. Nothing is flushed to zero.
- R10: binary32→bfloat16 keeps the 8-bit exponent and rounds the 23-bit fraction down to 7 bits under the selected mode, overflowing to infinity where R7 requires it.
- R11: Widening (`fmtSel` 2 = binary16→binary32, 3 = bfloat16→binary32) converts the 16-bit slot 2i+`partSel` into destination word i exactly, including binary16 subnormals, whatever `rndSel` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input vector is valid this cycle |
| inVec | input | 2048 | Source vector |
| inMask | input | 128 | Lane enables (see R3) |
| fmtSel | input | 2 | Direction and format (see R2, R11) |
| rndSel | input | 3 | Rounding mode for narrowing |
| partSel | input | 1 | 0 = even slots, 1 = odd slots |
| outValid | output | 1 | Result vector is valid |
| outVec | output | 2048 | Result vector |

## Verification
Every operation is due exactly seven rising edges after the edge that samples it. That holds for narrowing and widening alike, whatever the mode or the mask. When the driver issues an operation it stamps the expected vector with its due cycle. The monitor samples on the falling edge, pops the oldest entry whenever `outValid` is high, and requires both the data and the cycle number to match. Operations are issued back to back and also with gaps, so a result that arrives early, arrives late or is lost shows up as a mismatch or as an entry left in the queue.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;

  localparam int LAT = 7;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_AWAY      = 3'd1,
    RM_FLOOR     = 3'd2,
    RM_CEIL      = 3'd3,
    RM_ZERO      = 3'd4,
    RM_ODD       = 3'd5,
    RM_RSV6      = 3'd6,
    RM_RSV7      = 3'd7
  } rnd_e;

  typedef enum logic [1:0] {
    FMT_S2H = 2'd0,
    FMT_S2B = 2'd1,
    FMT_H2S = 2'd2,
    FMT_B2S = 2'd3
  } fmt_e;

  // strobes from control to datapath for the operation entering this cycle
  typedef struct packed {
    logic capture;
    logic narrow;
    logic isBf;
    logic part;
    rnd_e rnd;
  } strobe_t;

  // binary32 -> binary16 (isBf=0) or bfloat16 (isBf=1)
  function automatic logic [15:0] narrowF32(input logic [31:0] x, input logic isBf, input rnd_e rnd);
    logic        s;
    logic [7:0]  e;
    logic [22:0] f;
    logic [23:0] sig;
    logic [63:0] ext;
    logic [23:0] kept;
    logic        rb, st, inc;
    logic [31:0] enc, infEnc, maxEnc, nanEnc;
    logic [15:0] res;
    int manW, bias, expMax, emin, ue, eff, sh;
    s      = x[31];
    e      = x[30:23];
    f      = x[22:0];
    manW   = isBf ? 7 : 10;
    bias   = isBf ? 127 : 15;
    expMax = isBf ? 255 : 31;
    emin   = 1 - bias;
    infEnc = 32'(expMax) << manW;
    maxEnc = infEnc - 32'd1;
    nanEnc = infEnc | (32'd1 << (manW - 1));
    sig    = {(e != 8'd0), f};
    ue     = (e == 8'd0) ? -126 : (int'({24'd0, e}) - 127);
    eff    = (ue > emin) ? ue : emin;
    sh     = eff - ue + 23 - manW;
    if (sh > 40) begin
      kept = 24'd0;
      rb   = 1'b0;
      st   = |sig;
    end else begin
      ext  = {sig, 40'd0} >> sh;
      kept = ext[63:40];
      rb   = ext[39];
      st   = |ext[38:0];
    end
    case (rnd)
      RM_AWAY:          inc = rb | st;
      RM_FLOOR:         inc = s & (rb | st);
      RM_CEIL:          inc = ~s & (rb | st);
      RM_ZERO, RM_ODD:  inc = 1'b0;
      default:          inc = rb & (st | kept[0]);
    endcase
    if (rnd == RM_ODD) kept[0] = kept[0] | rb | st;
    enc = (32'(eff + bias - 1) << manW) + {8'd0, kept} + {31'd0, inc};
    if (e == 8'hFF) begin
      res = (f != 23'd0) ? {s, nanEnc[14:0]} : {s, infEnc[14:0]};
    end else if (enc >= infEnc) begin
      case (rnd)
        RM_ZERO, RM_ODD: res = {s, maxEnc[14:0]};
        RM_FLOOR:        res = s ? {s, infEnc[14:0]} : {s, maxEnc[14:0]};
        RM_CEIL:         res = s ? {s, maxEnc[14:0]} : {s, infEnc[14:0]};
        default:         res = {s, infEnc[14:0]};
      endcase
    end else begin
      res = {s, enc[14:0]};
    end
    return res;
  endfunction

  // binary16 (isBf=0) or bfloat16 (isBf=1) -> binary32, always exact
  function automatic logic [31:0] widenHalf(input logic [15:0] h, input logic isBf);
    logic        s;
    logic [4:0]  he;
    logic [9:0]  hm;
    logic [31:0] r;
    int p;
    s  = h[15];
    he = h[14:10];
    hm = h[9:0];
    p  = 0;
    if (isBf) begin
      if (h[14:7] == 8'hFF && h[6:0] != 7'd0) r = {s, 8'hFF, 1'b1, 22'd0};
      else                                    r = {h, 16'd0};
    end else if (he == 5'h1F) begin
      r = (hm != 10'd0) ? {s, 8'hFF, 1'b1, 22'd0} : {s, 8'hFF, 23'd0};
    end else if (he == 5'd0) begin
      if (hm == 10'd0) begin
        r = {s, 31'd0};
      end else begin
        for (int k = 0; k < 10; k++) if (hm[k]) p = k;
        r = {s, 8'(p + 103), 23'({13'd0, hm} << (23 - p))};
      end
    end else begin
      r = {s, ({3'd0, he} + 8'd112), hm, 13'd0};
    end
    return r;
  endfunction

endpackage

// File: rtl/fpcvt_ctrl.sv
module fpcvt_ctrl
  import fpcvt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] fmtSel,
  input  logic [2:0] rndSel,
  input  logic       partSel,
  output strobe_t    stb,
  output logic       outValid,
  output logic       outNarrow,
  output logic       outPart
);

  logic [LAT-1:0] validPipe, narrowPipe, partPipe;
  logic [2:0]     sinceRst;
  fmt_e           fmt;

  assign fmt         = fmt_e'(fmtSel);
  assign stb.capture = inValid;
  assign stb.narrow  = (fmt == FMT_S2H) || (fmt == FMT_S2B);
  assign stb.isBf    = (fmt == FMT_S2B) || (fmt == FMT_B2S);
  assign stb.part    = partSel;
  assign stb.rnd     = rnd_e'(rndSel);

  always_ff @(posedge clk) begin
    if (rst) begin
      validPipe  <= '0;
      narrowPipe <= '0;
      partPipe   <= '0;
      sinceRst   <= 3'd0;
    end else begin
      validPipe  <= {validPipe[LAT-2:0], inValid};
      narrowPipe <= {narrowPipe[LAT-2:0], stb.narrow};
      partPipe   <= {partPipe[LAT-2:0], partSel};
      sinceRst   <= (sinceRst == 3'd7) ? 3'd7 : sinceRst + 3'd1;
    end
  end

  assign outValid  = validPipe[LAT-1];
  assign outNarrow = narrowPipe[LAT-1];
  assign outPart   = partPipe[LAT-1];

  // R1: the result flag follows the input flag seven edges later
  a_r1_fixed_latency: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 3'd7) |-> (outValid == $past(inValid, 7)));

endmodule

// File: rtl/fpcvt_datapath.sv
module fpcvt_datapath
  import fpcvt_pkg::*;
#(
  parameter int VEC_W = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stb,
  input  logic [VEC_W-1:0] inVec,
  input  logic [VEC_W/16-1:0] inMask,
  output logic [VEC_W-1:0] outVec
);

  localparam int LANES = VEC_W / 32;

  logic [VEC_W-1:0] convVec;
  logic [VEC_W-1:0] pipe [LAT];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [31:0] srcWord;
    logic [15:0] narrowRes;
    logic [15:0] halfSrc;
    logic [31:0] wideRes;
    logic        laneOn;

    assign srcWord   = inVec[32*i +: 32];
    assign narrowRes = narrowF32(srcWord, stb.isBf, stb.rnd);
    assign halfSrc   = stb.part ? srcWord[31:16] : srcWord[15:0];
    assign wideRes   = widenHalf(halfSrc, stb.isBf);
    assign laneOn    = stb.narrow ? inMask[i] : inMask[2*i + int'(stb.part)];
    assign convVec[32*i +: 32] = !laneOn   ? 32'd0 :
                                 stb.narrow ? (stb.part ? {narrowRes, 16'd0} : {16'd0, narrowRes}) :
                                 wideRes;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LAT; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= stb.capture ? convVec : '0;
      for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign outVec = pipe[LAT-1];

  // R8: a binary32 NaN in lane 0 narrows to a quiet binary16 NaN
  a_r8_nan_quiet: assert property (@(posedge clk) disable iff (rst)
    (stb.narrow && !stb.isBf && inVec[30:23] == 8'hFF && inVec[22:0] != 23'd0)
      |-> (g_lane[0].narrowRes[14:9] == 6'h3F));

  // R3: a gated-off lane 0 contributes a zero word
  a_r3_lane_gated: assert property (@(posedge clk) disable iff (rst)
    (stb.narrow ? !inMask[0] : !inMask[int'(stb.part)]) |-> (convVec[31:0] == 32'd0));

endmodule

// File: rtl/vec_fp_narrow_cvt.sv
module vec_fp_narrow_cvt
  import fpcvt_pkg::*;
#(
  parameter int VEC_W = 2048
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [VEC_W-1:0]    inVec,
  input  logic [VEC_W/16-1:0] inMask,
  input  logic [1:0]          fmtSel,
  input  logic [2:0]          rndSel,
  input  logic                partSel,
  output logic                outValid,
  output logic [VEC_W-1:0]    outVec
);

  localparam int LANES = VEC_W / 32;
  localparam logic [VEC_W-1:0] EVEN_SLOTS = {LANES{32'h0000_FFFF}};

  strobe_t stb;
  logic    outNarrow, outPart;

  fpcvt_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .fmtSel   (fmtSel),
    .rndSel   (rndSel),
    .partSel  (partSel),
    .stb      (stb),
    .outValid (outValid),
    .outNarrow(outNarrow),
    .outPart  (outPart)
  );

  fpcvt_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .stb   (stb),
    .inVec (inVec),
    .inMask(inMask),
    .outVec(outVec)
  );

  // R1: no data leaks out while no result is due
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (outVec == '0));

  // R2: the half-slots not chosen by the part select stay zero
  a_r2_slot_zero: assert property (@(posedge clk) disable iff (rst)
    (outValid && outNarrow) |->
      ((outVec & (outPart ? EVEN_SLOTS : ~EVEN_SLOTS)) == '0));

endmodule

// File: tb/vec_fp_narrow_cvt_tb.sv
`timescale 1ns/1ps
module vec_fp_narrow_cvt_tb;

  typedef struct {
    logic [2047:0] expv;
    int            due;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst;
  logic          inValid;
  logic [2047:0] inVec;
  logic [127:0]  inMask;
  logic [1:0]    fmtSel;
  logic [2:0]    rndSel;
  logic          partSel;
  logic          outValid;
  logic [2047:0] outVec;

  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    done = 0;
  item_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vec_fp_narrow_cvt u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inVec(inVec), .inMask(inMask),
    .fmtSel(fmtSel), .rndSel(rndSel), .partSel(partSel),
    .outValid(outValid), .outVec(outVec)
  );

  task automatic issueNarrow(input logic [1:0] f, input logic [2:0] r, input logic p,
                             input logic [63:0] m, input logic [31:0] a, input logic [31:0] b,
                             input logic [15:0] ra, input logic [15:0] rb, input string tag);
    item_t it;
    logic [15:0] w;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      inVec[32*i +: 32] = (i % 2 == 0) ? a : b;
      w = (i % 2 == 0) ? ra : rb;
      it.expv[32*i +: 32] = !m[i] ? 32'd0 : (p ? {w, 16'd0} : {16'd0, w});
    end
    inMask  = {~m, m};
    fmtSel  = f;
    rndSel  = r;
    partSel = p;
    inValid = 1'b1;
    it.due  = cyc + 7;
    it.tag  = tag;
    sb.push_back(it);
  endtask

  task automatic issueWiden(input logic [1:0] f, input logic [2:0] r, input logic p,
                            input logic [127:0] m, input logic [15:0] a, input logic [15:0] b,
                            input logic [31:0] ra, input logic [31:0] rb, input string tag);
    item_t it;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      inVec[32*i +: 32] = {b, a};
      it.expv[32*i +: 32] = m[2*i + int'(p)] ? (p ? rb : ra) : 32'd0;
    end
    inMask  = m;
    fmtSel  = f;
    rndSel  = r;
    partSel = p;
    inValid = 1'b1;
    it.due  = cyc + 7;
    it.tag  = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      inVec   = ~inVec;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && outValid) begin
      nChecks++;
      if (sb.size() == 0) begin
        nFails++;
        $display("FAIL R1 unexpected result at cycle %0d: actual valid 1 expected 0", cyc);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (cyc != it.due) begin
          nFails++;
          $display("FAIL %s timing: actual cycle %0d expected %0d", it.tag, cyc, it.due);
        end else if (outVec !== it.expv) begin
          int lane;
          lane = 0;
          for (int i = 63; i >= 0; i--) if (outVec[32*i +: 32] !== it.expv[32*i +: 32]) lane = i;
          nFails++;
          $display("FAIL %s lane %0d: actual %h expected %h", it.tag, lane,
                   outVec[32*lane +: 32], it.expv[32*lane +: 32]);
        end
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R1 watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; inVec = '0; inMask = '0;
    fmtSel = 2'd0; rndSel = 3'd0; partSel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0 || outVec !== '0) begin
      nFails++;
      $display("FAIL R1 reset state: actual valid %b expected 0", outValid);
    end

    // back-to-back narrowing to binary16
    issueNarrow(2'd0, 3'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h3F80_0000, 32'hC000_0000, 16'h3C00, 16'hC000, "R2 even placement");
    issueNarrow(2'd0, 3'd0, 1'b1, 64'h5A5A_0FF0_3C3C_9669, 32'h3F80_1000, 32'h3F80_3000, 16'h3C00, 16'h3C02, "R4 ties to even, R3 mask");
    issueNarrow(2'd0, 3'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h477F_E000, 32'h477F_F000, 16'h7BFF, 16'h7C00, "R7 nearest overflow");
    issueNarrow(2'd0, 3'd4, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h477F_F000, 32'hC974_2400, 16'h7BFF, 16'hFBFF, "R5 toward zero, R7");
    issueNarrow(2'd0, 3'd2, 1'b0, 64'hFFFF_0000_FFFF_0000, 32'hBF80_0800, 32'hC974_2400, 16'hBC01, 16'hFC00, "R5 floor, R7");
    issueNarrow(2'd0, 3'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'hBF80_0800, 32'h4974_2400, 16'hBC00, 16'h7C00, "R5 ceiling, R7");
    issueNarrow(2'd0, 3'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 32'hC974_2400, 32'h3380_0000, 16'hFBFF, 16'h0001, "R7 ceiling negative overflow");
    issueNarrow(2'd0, 3'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h3F80_1000, 32'h3300_0000, 16'h3C01, 16'h0001, "R5 away, R9");
    idle(2);
    issueNarrow(2'd0, 3'd5, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h3F80_1000, 32'hC974_2400, 16'h3C01, 16'hFBFF, "R6 round to odd");
    issueNarrow(2'd0, 3'd5, 1'b0, 64'h0000_0000_FFFF_FFFF, 32'h3300_0000, 32'h3F80_0000, 16'h0001, 16'h3C00, "R6 odd subnormal, R3");
    issueNarrow(2'd0, 3'd0, 1'b0, 64'h0123_4567_89AB_CDEF, 32'h3380_0000, 32'h3300_0000, 16'h0001, 16'h0000, "R9 subnormal");
    issueNarrow(2'd0, 3'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h3340_0000, 32'h7F80_0001, 16'h0001, 16'h7E00, "R9 subnormal, R8 NaN");
    issueNarrow(2'd0, 3'd6, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h7F80_0000, 32'hFFC0_0001, 16'h7C00, 16'hFE00, "R8 inf and NaN, R4 code 6");
    // bfloat16
    issueNarrow(2'd1, 3'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h3F80_8000, 32'h3F81_8000, 16'h3F80, 16'h3F82, "R10 ties to even");
    issueNarrow(2'd1, 3'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h3F80_8000, 32'h7F80_0001, 16'h3F81, 16'h7FC0, "R10 away, R8");
    issueNarrow(2'd1, 3'd7, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h7F7F_FFFF, 32'h3F80_0000, 16'h7F80, 16'h3F80, "R10 overflow, R4 code 7");
    issueNarrow(2'd1, 3'd4, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h7F7F_FFFF, 32'h0000_0001, 16'h7F7F, 16'h0000, "R10 toward zero, R7");
    idle(1);
    // widening
    issueWiden(2'd2, 3'd0, 1'b0, {4{32'hFFFF_FFFF}}, 16'h3C00, 16'h0001, 32'h3F80_0000, 32'h3380_0000, "R11 even source");
    issueWiden(2'd2, 3'd3, 1'b1, {4{32'h0F0F_A5A5}}, 16'h3C00, 16'h0001, 32'h3F80_0000, 32'h3380_0000, "R11 odd source, R3 mask");
    issueWiden(2'd2, 3'd4, 1'b0, {4{32'hFFFF_FFFF}}, 16'h7BFF, 16'h03FF, 32'h477F_E000, 32'h387F_C000, "R11 max finite");
    issueWiden(2'd2, 3'd5, 1'b1, {4{32'hFFFF_FFFF}}, 16'h7BFF, 16'h03FF, 32'h477F_E000, 32'h387F_C000, "R11 subnormal, rounding ignored");
    issueWiden(2'd2, 3'd0, 1'b0, {4{32'hFFFF_FFFF}}, 16'h7D00, 16'h7C00, 32'h7FC0_0000, 32'h7F80_0000, "R8 widen NaN");
    issueWiden(2'd2, 3'd2, 1'b1, {4{32'hFFFF_FFFF}}, 16'h7D00, 16'h7C00, 32'h7FC0_0000, 32'h7F80_0000, "R8 widen inf");
    issueWiden(2'd2, 3'd1, 1'b0, {4{32'h3333_CCCC}}, 16'h8000, 16'h3C00, 32'h8000_0000, 32'h3F80_0000, "R11 negative zero");
    issueWiden(2'd3, 3'd0, 1'b0, {4{32'hFFFF_FFFF}}, 16'h3F80, 16'hFF81, 32'h3F80_0000, 32'hFFC0_0000, "R11 bfloat16 even");
    issueWiden(2'd3, 3'd2, 1'b1, {4{32'hFFFF_FFFF}}, 16'h0001, 16'hFF81, 32'h0001_0000, 32'hFFC0_0000, "R8 bfloat16 NaN");
    issueWiden(2'd3, 3'd4, 1'b0, {4{32'hFFFF_FFFF}}, 16'h0001, 16'hFF81, 32'h0001_0000, 32'hFFC0_0000, "R11 bfloat16 subnormal");
    idle(14);

    nChecks++;
    if (sb.size() != 0) begin
      nFails++;
      $display("FAIL R1 missing results: actual %0d pending expected 0", sb.size());
    end
    finishRun();
  end

endmodule